// File: doc/BRIEF.md
# High-Speed Chirp Timing Monitor

This block listens passively to the decoded bus line state while a host runs the high-speed detection handshake. The host sends a train of alternating K and J chirps. The monitor measures every chirp in clock cycles and checks it against an inclusive duration window. The window is derived from a clock-frequency parameter and from limits given in microseconds. A host may send hundreds of chirps. Each chirp is checked on its own, so a single bad chirp in the middle of a long train is reported with its exact position and its measured length.

The input is a two-bit line-state code, one sample per clock cycle. The monitor keeps a running count of the chirps that have completed in the current sequence. It raises a flag once the minimum sequence length is reached. It emits single-cycle pulses for timing errors, for broken alternation and for the end of a sequence.

The control is a four-state machine:
- **IDLE**: waits for an SE0 sample (transition *arm*).
- **ARMED**: a K starts a sequence (transition *start*). A J or other code returns the machine to IDLE (transition *disarm*).
- **CHIRP**: a same-state sample extends the chirp (*extend*). The opposite state closes it and opens the next one (*flip*). An other code closes it and enters GAP (*break*). SE0 closes it and ends the sequence back in ARMED (*finish*).
- **GAP**: K or J resumes in CHIRP (*resume*). SE0 ends the sequence in ARMED (*finish*). Too many other codes end the sequence in IDLE (*abandon*).

Top module: `chirp_monitor`

## Requirements
- R1: The line-state code is 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 other. A sequence starts only on a K sample that directly follows one or more SE0 samples. From reset, and after a J or other code while armed, K samples are ignored until an SE0 sample has been seen.
- R2: A chirp's length is the number of consecutive samples of its state (K or J). The chirp closes on the first sample of the opposite state, of SE0 or of the other code.
- R3: With MIN_CYC = (CLK_HZ/1000)*MIN_US/1000 and MAX_CYC = (CLK_HZ/1000)*MAX_US/1000, a closed chirp shorter than MIN_CYC or longer than MAX_CYC raises time_err_valid for exactly the one cycle after its closing sample. The pulse carries time_err_idx (the zero-based position of the chirp in the sequence), time_err_len (its length) and time_err_long (1 for too long, 0 for too short). Lengths of exactly MIN_CYC or MAX_CYC raise no error.
- R4: chirp_count equals the number of chirps closed in the current sequence. It is updated in the cycle after each closing sample, clears to zero when a new sequence starts, and holds its value after the sequence ends.
- R5: min_met is high exactly while chirp_count is at least MIN_CHIRPS (default 6, that is three K/J cycles).
- R6: chirp_count, time_err_idx and alt_err_idx saturate at 2^IDX_W-1 and never wrap.
- R7: Inside a sequence, up to GAP_MAX consecutive other samples are tolerated and counted in no chirp. When the line then returns to K or J, a new chirp starts. If that chirp has the same state as the chirp before the gap, alt_err_valid pulses for one cycle with alt_err_idx set to the new chirp's position.
- R8: A sequence ends on an SE0 sample, after which the monitor is armed again. It also ends on the (GAP_MAX+1)-th consecutive other sample, after which the monitor is idle. seq_done pulses for exactly one cycle after the ending sample.
- R9: The length measurement saturates at 2^LEN_W-1 (LEN_W = clog2(MAX_CYC+1)+1). A chirp that long is reported as too long with that saturated length.
- R10: While reset is asserted and just after it is released, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 other |
| chirp_count | output | IDX_W | Chirps closed in the current or last sequence, saturating |
| min_met | output | 1 | Minimum chirp count reached |
| time_err_valid | output | 1 | One-cycle pulse: a chirp fell outside the window |
| time_err_idx | output | IDX_W | Position of the offending chirp |
| time_err_len | output | LEN_W | Measured length of the offending chirp in cycles |
| time_err_long | output | 1 | 1 when the chirp was too long, 0 when too short |
| alt_err_valid | output | 1 | One-cycle pulse: same-state chirp after a gap |
| alt_err_idx | output | IDX_W | Position of the repeated-state chirp |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that line_state always holds one of its four codes, already synchronised to clk and free of unknown values. They also assume that MIN_CHIRPS fits in IDX_W bits, so the rise of min_met lands exactly on that count. The bench changes line_state only on falling clock edges and holds each code for whole cycles. It uses a clock-frequency parameter that gives a 40 to 60 cycle window, so that trains of a dozen or more chirps, window-edge lengths and gap lengths at and just past the tolerance stay short. A second instance with a narrow counter shares the same input and reaches the saturation limit.

// File: rtl/chirp_mon_pkg.sv
package chirp_mon_pkg;

    // Decoded line-state codes presented each cycle.
    typedef enum logic [1:0] {
        LS_SE0   = 2'b00,
        LS_J     = 2'b01,
        LS_K     = 2'b10,
        LS_OTHER = 2'b11
    } line_t;

    // Monitor control states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_CHIRP = 2'b10,
        ST_GAP   = 2'b11
    } mon_state_t;

endpackage

// File: rtl/chirp_sat_counter.sv
// Saturating up-counter with a load-to-one input, used for chirp and gap lengths.
module chirp_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= ONE;
        end else if (inc && (value != TOP)) begin
            value <= value + ONE;
        end
    end
endmodule

// File: rtl/chirp_window_check.sv
// Compares a measured chirp length against the inclusive duration window.
module chirp_window_check #(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned LO_CYC = 40,
    parameter int unsigned HI_CYC = 60
) (
    input  logic [LEN_W-1:0] len,
    output logic             too_short,
    output logic             too_long
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(LO_CYC);
    localparam logic [LEN_W-1:0] HI = LEN_W'(HI_CYC);

    assign too_short = (len < LO);
    assign too_long  = (len > HI);
endmodule

// File: rtl/chirp_seq_counter.sv
// Saturating count of closed chirps in a sequence, with the minimum-length flag.
module chirp_seq_counter #(
    parameter int unsigned IDX_W      = 16,
    parameter int unsigned MIN_CHIRPS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [IDX_W-1:0] count,
    output logic             min_met
);
    localparam logic [IDX_W-1:0] TOP = '1;
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
    localparam bit REACHABLE =
        (longint'(MIN_CHIRPS) <= ((longint'(1) << IDX_W) - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bump && (count != TOP)) begin
            count <= count + ONE;
        end
    end

    generate
        if (REACHABLE) begin : g_flag
            localparam logic [IDX_W-1:0] THRESH = IDX_W'(MIN_CHIRPS);
            assign min_met = (count >= THRESH);
        end else begin : g_never
            assign min_met = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/chirp_monitor.sv
module chirp_monitor
    import chirp_mon_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 60_000_000,
    parameter int unsigned MIN_US     = 40,
    parameter int unsigned MAX_US     = 60,
    parameter int unsigned MIN_CHIRPS = 6,
    parameter int unsigned IDX_W      = 16,
    parameter int unsigned GAP_MAX    = 4,
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000,
    localparam int unsigned MIN_CYC    = CYC_PER_MS * MIN_US / 1000,
    localparam int unsigned MAX_CYC    = CYC_PER_MS * MAX_US / 1000,
    localparam int unsigned LEN_W      = $clog2(MAX_CYC + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       line_state,
    output logic [IDX_W-1:0] chirp_count,
    output logic             min_met,
    output logic             time_err_valid,
    output logic [IDX_W-1:0] time_err_idx,
    output logic [LEN_W-1:0] time_err_len,
    output logic             time_err_long,
    output logic             alt_err_valid,
    output logic [IDX_W-1:0] alt_err_idx,
    output logic             seq_done
);
    localparam int unsigned GAP_W = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(GAP_MAX);

    line_t      ls;
    mon_state_t state, nxt_state;
    logic       cur_k, nxt_cur_k;

    // Events decoded from the current state and line sample.
    logic ev_start_seq, ev_start_chirp, ev_close, ev_alt, ev_end;
    logic len_inc, gap_load, gap_inc;

    logic [LEN_W-1:0] len_q;
    logic [GAP_W-1:0] gap_q;
    logic             too_short, too_long;

    assign ls = line_t'(line_state);

    chirp_sat_counter #(.W(LEN_W)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ev_start_chirp),
        .inc   (len_inc),
        .value (len_q)
    );

    chirp_sat_counter #(.W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .inc   (gap_inc),
        .value (gap_q)
    );

    chirp_window_check #(
        .LEN_W  (LEN_W),
        .LO_CYC (MIN_CYC),
        .HI_CYC (MAX_CYC)
    ) u_win (
        .len       (len_q),
        .too_short (too_short),
        .too_long  (too_long)
    );

    chirp_seq_counter #(
        .IDX_W      (IDX_W),
        .MIN_CHIRPS (MIN_CHIRPS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ev_start_seq),
        .bump    (ev_close),
        .count   (chirp_count),
        .min_met (min_met)
    );

    // Next-state and event decode.
    always_comb begin
        nxt_state      = state;
        nxt_cur_k      = cur_k;
        ev_start_seq   = 1'b0;
        ev_start_chirp = 1'b0;
        ev_close       = 1'b0;
        ev_alt         = 1'b0;
        ev_end         = 1'b0;
        len_inc        = 1'b0;
        gap_load       = 1'b0;
        gap_inc        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ls == LS_SE0) begin
                    nxt_state = ST_ARMED;           // arm
                end
            end
            ST_ARMED: begin
                unique case (ls)
                    LS_K: begin                     // start
                        ev_start_seq   = 1'b1;
                        ev_start_chirp = 1'b1;
                        nxt_cur_k      = 1'b1;
                        nxt_state      = ST_CHIRP;
                    end
                    LS_SE0: begin
                        nxt_state = ST_ARMED;
                    end
                    LS_J, LS_OTHER: begin           // disarm
                        nxt_state = ST_IDLE;
                    end
                endcase
            end
            ST_CHIRP: begin
                unique case (ls)
                    LS_K, LS_J: begin
                        if ((ls == LS_K) == cur_k) begin
                            len_inc = 1'b1;         // extend
                        end else begin              // flip
                            ev_close       = 1'b1;
                            ev_start_chirp = 1'b1;
                            nxt_cur_k      = ~cur_k;
                        end
                    end
                    LS_OTHER: begin                 // break
                        ev_close  = 1'b1;
                        gap_load  = 1'b1;
                        nxt_state = ST_GAP;
                    end
                    LS_SE0: begin                   // finish
                        ev_close  = 1'b1;
                        ev_end    = 1'b1;
                        nxt_state = ST_ARMED;
                    end
                endcase
            end
            ST_GAP: begin
                unique case (ls)
                    LS_K, LS_J: begin               // resume
                        ev_start_chirp = 1'b1;
                        nxt_cur_k      = (ls == LS_K);
                        ev_alt         = ((ls == LS_K) == cur_k);
                        nxt_state      = ST_CHIRP;
                    end
                    LS_OTHER: begin
                        if (gap_q >= GAP_LIMIT) begin   // abandon
                            ev_end    = 1'b1;
                            nxt_state = ST_IDLE;
                        end else begin
                            gap_inc = 1'b1;
                        end
                    end
                    LS_SE0: begin                   // finish
                        ev_end    = 1'b1;
                        nxt_state = ST_ARMED;
                    end
                endcase
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur_k <= 1'b0;
        end else begin
            state <= nxt_state;
            cur_k <= nxt_cur_k;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_err_valid <= 1'b0;
            time_err_idx   <= '0;
            time_err_len   <= '0;
            time_err_long  <= 1'b0;
            alt_err_valid  <= 1'b0;
            alt_err_idx    <= '0;
            seq_done       <= 1'b0;
        end else begin
            time_err_valid <= ev_close && (too_short || too_long);
            if (ev_close && (too_short || too_long)) begin
                time_err_idx  <= chirp_count;
                time_err_len  <= len_q;
                time_err_long <= too_long;
            end
            alt_err_valid <= ev_alt;
            if (ev_alt) begin
                alt_err_idx <= chirp_count;
            end
            seq_done <= ev_end;
        end
    end
endmodule

// File: rtl/chirp_monitor_checker.sv
module chirp_monitor_checker
    import chirp_mon_pkg::*;
#(
    parameter int unsigned IDX_W      = 16,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned MIN_CYC    = 40,
    parameter int unsigned MAX_CYC    = 60,
    parameter int unsigned MIN_CHIRPS = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       line_state,
    input mon_state_t       state,
    input logic [IDX_W-1:0] chirp_count,
    input logic             min_met,
    input logic             time_err_valid,
    input logic [LEN_W-1:0] time_err_len,
    input logic             time_err_long,
    input logic             alt_err_valid,
    input logic             seq_done
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_CYC);
    localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_CYC);
    localparam logic [IDX_W-1:0] THRESH = IDX_W'(MIN_CHIRPS);

    assert_start_on_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHIRP && $past(state) == ST_ARMED)
            |-> ($past(line_state) == 2'b10 && chirp_count == '0));

    assert_outside_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        time_err_valid |-> (time_err_len < LO || time_err_len > HI));

    assert_long_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        time_err_valid |-> (time_err_long == (time_err_len > HI)));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chirp_count != $past(chirp_count))
            |-> (({1'b0, chirp_count} == {1'b0, $past(chirp_count)} + {{IDX_W{1'b0}}, 1'b1})
                 || (chirp_count == '0 && $past(state) == ST_ARMED)));

    assert_min_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(min_met) |-> (chirp_count == THRESH));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chirp_count) == '1 && $past(state) != ST_ARMED) |-> (chirp_count == '1));

    assert_alt_after_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alt_err_valid |-> ($past(state) == ST_GAP));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
endmodule

bind chirp_monitor chirp_monitor_checker #(
    .IDX_W      (IDX_W),
    .LEN_W      (LEN_W),
    .MIN_CYC    (MIN_CYC),
    .MAX_CYC    (MAX_CYC),
    .MIN_CHIRPS (MIN_CHIRPS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_state     (line_state),
    .state          (state),
    .chirp_count    (chirp_count),
    .min_met        (min_met),
    .time_err_valid (time_err_valid),
    .time_err_len   (time_err_len),
    .time_err_long  (time_err_long),
    .alt_err_valid  (alt_err_valid),
    .seq_done       (seq_done)
);

// File: tb/chirp_monitor_test.sv
`timescale 1ns/1ps
module chirp_monitor_test;
    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] JJ  = 2'b01;
    localparam logic [1:0] KK  = 2'b10;
    localparam logic [1:0] OTH = 2'b11;
    localparam int IDX_W = 16;
    localparam int SAT_W = 3;
    localparam int LEN_W = 7;   // clog2(61)+1 for a 40..60 cycle window

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] line = OTH;

    always #4 clk = ~clk;   // 125 MHz

    logic [IDX_W-1:0] chirp_count, time_err_idx, alt_err_idx;
    logic [LEN_W-1:0] time_err_len;
    logic min_met, time_err_valid, time_err_long, alt_err_valid, seq_done;

    logic [SAT_W-1:0] s_count, s_tidx, s_aidx;
    logic [LEN_W-1:0] s_tlen;
    logic s_min, s_tv, s_tlong, s_av, s_done;

    chirp_monitor #(.CLK_HZ(1_000_000), .MIN_US(40), .MAX_US(60), .MIN_CHIRPS(6),
                    .IDX_W(IDX_W), .GAP_MAX(4)) uut (
        .clk(clk), .rst_n(rst_n), .line_state(line),
        .chirp_count(chirp_count), .min_met(min_met),
        .time_err_valid(time_err_valid), .time_err_idx(time_err_idx),
        .time_err_len(time_err_len), .time_err_long(time_err_long),
        .alt_err_valid(alt_err_valid), .alt_err_idx(alt_err_idx),
        .seq_done(seq_done));

    chirp_monitor #(.CLK_HZ(1_000_000), .MIN_US(40), .MAX_US(60), .MIN_CHIRPS(6),
                    .IDX_W(SAT_W), .GAP_MAX(4)) uut_sat (
        .clk(clk), .rst_n(rst_n), .line_state(line),
        .chirp_count(s_count), .min_met(s_min),
        .time_err_valid(s_tv), .time_err_idx(s_tidx),
        .time_err_len(s_tlen), .time_err_long(s_tlong),
        .alt_err_valid(s_av), .alt_err_idx(s_aidx),
        .seq_done(s_done));

    int n_checks = 0;
    int n_fail = 0;

    // Event recorder, sampling 2 ns after each rising edge.
    int n_terr = 0, n_aerr = 0, n_done = 0, n_sterr = 0;
    int terr_idx [16];
    int terr_len [16];
    int terr_long[16];
    int aerr_idx [16];
    int s_last_idx = 0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (time_err_valid) begin
                terr_idx[n_terr % 16]  = int'(time_err_idx);
                terr_len[n_terr % 16]  = int'(time_err_len);
                terr_long[n_terr % 16] = int'(time_err_long);
                n_terr++;
            end
            if (alt_err_valid) begin
                aerr_idx[n_aerr % 16] = int'(alt_err_idx);
                n_aerr++;
            end
            if (seq_done) n_done++;
            if (s_tv) begin
                s_last_idx = int'(s_tidx);
                n_sterr++;
            end
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] s, input int n);
        repeat (n) begin
            @(negedge clk);
            line = s;
        end
    endtask

    // R10 reset state, then R1: no start without a preceding SE0, and disarm on J.
    task automatic t_reset_and_arming();
        int d0;
        check("R10", "chirp_count", chirp_count, 0);
        check("R10", "min_met", min_met, 0);
        check("R10", "time_err_valid", time_err_valid, 0);
        check("R10", "alt_err_valid", alt_err_valid, 0);
        check("R10", "seq_done", seq_done, 0);
        d0 = n_done;
        drive(KK, 50); drive(JJ, 50); drive(KK, 50); drive(OTH, 3);
        check("R1", "count without SE0", chirp_count, 0);
        drive(SE0, 3); drive(JJ, 5); drive(KK, 50); drive(JJ, 50); drive(OTH, 3);
        check("R1", "count after disarm", chirp_count, 0);
        check("R1", "no done when never started", n_done - d0, 0);
    endtask

    // R2/R4/R5: clean eight-chirp train.
    task automatic t_good_train();
        int t0, d0;
        t0 = n_terr; d0 = n_done;
        drive(SE0, 3);
        for (int j = 0; j < 8; j++) begin
            drive((j % 2 == 0) ? KK : JJ, 50);
            if (j == 5) begin
                check("R5", "min_met at five closed", min_met, 0);
                check("R4", "count at five closed", chirp_count, 5);
            end
            if (j == 6) begin
                check("R5", "min_met at six closed", min_met, 1);
                check("R4", "count at six closed", chirp_count, 6);
            end
        end
        drive(SE0, 3);
        check("R4", "final count", chirp_count, 8);
        check("R5", "min_met held", min_met, 1);
        check("R3", "no timing errors", n_terr - t0, 0);
        check("R8", "one done pulse", n_done - d0, 1);
    endtask

    // R3: window edges, exact pulse cycle, short and long reports.
    task automatic t_window();
        int t0;
        t0 = n_terr;
        drive(SE0, 3); drive(KK, 50); drive(JJ, 39);
        drive(KK, 1);
        check("R3", "no pulse before closing sample clocks", time_err_valid, 0);
        drive(KK, 1);
        check("R3", "pulse after closing sample", time_err_valid, 1);
        check("R3", "short idx", time_err_idx, 1);
        check("R3", "short len", time_err_len, 39);
        check("R3", "short flag", time_err_long, 0);
        drive(KK, 38);
        drive(JJ, 60); drive(KK, 61); drive(JJ, 50); drive(SE0, 3);
        check("R3", "two errors only (40 and 60 accepted)", n_terr - t0, 2);
        check("R3", "long idx", terr_idx[(t0 + 1) % 16], 4);
        check("R3", "long len", terr_len[(t0 + 1) % 16], 61);
        check("R3", "long flag", terr_long[(t0 + 1) % 16], 1);
    endtask

    // R3/R4: one bad chirp deep in a thirty-chirp train.
    task automatic t_mid_error();
        int t0;
        t0 = n_terr;
        drive(SE0, 3);
        for (int j = 0; j < 30; j++)
            drive((j % 2 == 0) ? KK : JJ, (j == 17) ? 35 : 50);
        drive(SE0, 3);
        check("R3", "single mid error", n_terr - t0, 1);
        check("R3", "mid error idx", terr_idx[t0 % 16], 17);
        check("R3", "mid error len", terr_len[t0 % 16], 35);
        check("R4", "count of thirty", chirp_count, 30);
    endtask

    // R7: gaps tolerated; same state after a gap flagged.
    task automatic t_gap_alt();
        int a0, t0, d0;
        a0 = n_aerr; t0 = n_terr; d0 = n_done;
        drive(SE0, 3); drive(KK, 50); drive(JJ, 50);
        drive(OTH, 4); drive(JJ, 50);
        drive(OTH, 2); drive(KK, 50); drive(JJ, 50);
        drive(SE0, 3);
        check("R7", "one alternation error", n_aerr - a0, 1);
        check("R7", "alternation idx", aerr_idx[a0 % 16], 2);
        check("R7", "gap not timed", n_terr - t0, 0);
        check("R7", "count across gaps", chirp_count, 5);
        check("R8", "done after gapped train", n_done - d0, 1);
    endtask

    // R8/R4: long gap ends the sequence and leaves the monitor idle.
    task automatic t_gap_end();
        int d0;
        d0 = n_done;
        drive(SE0, 3); drive(KK, 50); drive(JJ, 50);
        drive(OTH, 4);
        check("R8", "no done inside tolerance", n_done - d0, 0);
        drive(OTH, 3);
        check("R8", "done on fifth other", n_done - d0, 1);
        check("R8", "count at abandon", chirp_count, 2);
        drive(KK, 50); drive(JJ, 5);
        check("R8", "idle after abandon ignores K", chirp_count, 2);
        drive(SE0, 3); drive(KK, 50);
        check("R4", "count cleared on new start", chirp_count, 0);
        drive(JJ, 50); drive(SE0, 3);
        check("R4", "count of new sequence", chirp_count, 2);
        check("R8", "second done", n_done - d0, 2);
    endtask

    // R9: length saturates and is reported as too long.
    task automatic t_len_sat();
        int t0;
        t0 = n_terr;
        drive(SE0, 3); drive(KK, 200); drive(JJ, 50); drive(SE0, 3);
        check("R9", "one error", n_terr - t0, 1);
        check("R9", "saturated len", terr_len[t0 % 16], 127);
        check("R9", "long flag", terr_long[t0 % 16], 1);
    endtask

    // R6: narrow instance saturates its count and index.
    task automatic t_count_sat();
        int t0, s0;
        t0 = n_terr; s0 = n_sterr;
        drive(SE0, 3);
        for (int j = 0; j < 12; j++)
            drive((j % 2 == 0) ? KK : JJ, (j == 10) ? 30 : 50);
        drive(SE0, 3);
        check("R6", "wide count", chirp_count, 12);
        check("R6", "narrow count saturated", s_count, 7);
        check("R6", "narrow min_met", s_min, 1);
        check("R6", "wide idx", terr_idx[t0 % 16], 10);
        check("R6", "narrow error seen", n_sterr - s0, 1);
        check("R6", "narrow idx saturated", s_last_idx, 7);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_arming();
        t_good_train();
        t_window();
        t_mid_error();
        t_gap_alt();
        t_gap_end();
        t_len_sat();
        t_count_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule